// File: doc/BRIEF.md
# PHY Power-Up Initialization Sequencer

This block brings an attached PHY to a usable default state with no help from software. As soon as reset is released it starts a fixed list of accesses to the PHY's 8-bit registers. Most steps are read-modify-write operations: the block reads a register, ORs a set-bit mask into the value and writes the result back. Partway through the list it waits for the pad calibration to finish, and the last step writes the default operating mode directly.

The block talks to the PHY register port through a request channel with valid/ready handshaking. A request carries an address, a write flag and write data. It stays on the port with all fields stable until the PHY raises ready. Only one access is in flight at a time: after a request is accepted, the block raises no new request until the PHY returns a response. The response is a one-cycle `phy_rsp_valid` carrying read data and an error flag. The response path has no back-pressure, because the block always accepts it.

The run ends with either `done` or `error`. If any response reports an error, or an access or the calibration poll takes too long, the run stops at once and `error` is raised. The timeout window is `CLK_MHZ * TIMEOUT_US` clock cycles, which is 100 µs by default. A `start` pulse given after the run has ended clears the result and runs the whole list again.

Top module: `phy_boot_seq`

## Requirements
- R1: The list starts on its own in the first cycle after reset is released. During reset `done`, `error` and `phy_req_valid` are 0. A `start` pulse given while `done` or `error` is high clears both flags in the next cycle and restarts the list from its first step.
- R2: The accesses run in this exact order:
  - read-modify-write of 0x01 with mask 0x42 (bits 6 and 1);
  - read-modify-write of 0x02 with mask 0x02;
  - calibration poll of 0x03;
  - read-modify-writes of 0x06 with 0x03, 0x08 with 0x02, 0x20 with 0x01, 0x07 with 0xFF, 0x09 with 0xFF, 0x21 with 0xFF, 0x22 with 0x01, 0x23 with 0x01 and 0x0F with 0x07;
  - a write of 0x04 to register 0x11, with no read of 0x11 before it.
- R3: Each read-modify-write reads its register and then writes the same address with the value read ORed with the step's mask. All other bits keep the value that was read.
- R4: The calibration poll reads register 0x03 again and again. The first read that returns bit 4 set ends the poll, and the next step follows.
- R5: A poll read that returns bit 4 clear after the poll has lasted the timeout window ends the run with `error`. No further step is issued.
- R6: A response with `phy_rsp_err` = 1 ends the run with `error`. No request follows it.
- R7: An access that is not accepted and answered within the timeout window, counted from its issue, ends the run with `error`.
- R8: `done` and `error` are never high together. Each stays high until the next `start`, and while either is high no request is made.
- R9: Once `phy_req_valid` is raised, it stays high with address, write flag and data stable until `phy_req_ready` is seen. After a handshake, the next cycle has no request.
- R10: A `start` pulse while a run is in progress has no effect. The run continues, and its access sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restart pulse, taken only when the previous run has ended |
| done | output | 1 | List completed without fault |
| error | output | 1 | Run aborted by an access fault or a timeout |
| phy_req_valid | output | 1 | Request present on the PHY port |
| phy_req_ready | input | 1 | PHY accepts the request this cycle |
| phy_req_write | output | 1 | 1 = write, 0 = read |
| phy_req_addr | output | 8 | PHY register address |
| phy_req_wdata | output | 8 | Write data |
| phy_rsp_valid | input | 1 | One-cycle response to the accepted request |
| phy_rsp_rdata | input | 8 | Read data (ignored for writes) |
| phy_rsp_err | input | 1 | Access failed |

## Verification
The assertions check the following on every cycle:
- the request holds stable and one access is in flight at a time;
- no request is made after an error response;
- `done` and `error` persist once raised;
- register 0x11 is never read and only ever receives 0x04;
- writes to 0x01 always carry bits 6 and 1;
- the timeout counters saturate.

Only the bench scenarios can show the rest:
- the complete access order, with the OR-merged write data for random register contents;
- the poll length for different calibration delays;
- aborts at a chosen access;
- both timeout paths;
- restart, and that `start` is ignored during a run.

// File: rtl/phy_boot_pkg.sv
package phy_boot_pkg;

  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int STEP_COUNT = 13;
  localparam int CAL_BIT    = 4;

  typedef enum logic [1:0] {
    K_RMW   = 2'd0,
    K_POLL  = 2'd1,
    K_WRITE = 2'd2
  } step_kind_e;

  typedef struct packed {
    step_kind_e          kind;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   mask;   // OR mask, or direct value for K_WRITE
  } step_t;

  function automatic step_t mk(input step_kind_e k, input logic [7:0] a,
                               input logic [7:0] m);
    step_t s;
    s.kind = k;
    s.addr = a;
    s.mask = m;
    return s;
  endfunction

  // Ordered init list; order is behaviour (calibration poll sits after pads)
  function automatic step_t step_at(input int i);
    case (i)
      0:       return mk(K_RMW,   8'h01, 8'h42);
      1:       return mk(K_RMW,   8'h02, 8'h02);
      2:       return mk(K_POLL,  8'h03, 8'h10);
      3:       return mk(K_RMW,   8'h06, 8'h03);
      4:       return mk(K_RMW,   8'h08, 8'h02);
      5:       return mk(K_RMW,   8'h20, 8'h01);
      6:       return mk(K_RMW,   8'h07, 8'hFF);
      7:       return mk(K_RMW,   8'h09, 8'hFF);
      8:       return mk(K_RMW,   8'h21, 8'hFF);
      9:       return mk(K_RMW,   8'h22, 8'h01);
      10:      return mk(K_RMW,   8'h23, 8'h01);
      11:      return mk(K_RMW,   8'h0F, 8'h07);
      default: return mk(K_WRITE, 8'h11, 8'h04);
    endcase
  endfunction

endpackage

// File: rtl/phy_boot_timer.sv
module phy_boot_timer #(
  parameter int unsigned LIMIT = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (en && !expired)  cnt <= cnt + 1'b1;
  end

  AST_TIMER_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !clr |=> expired); // R7

endmodule

// File: rtl/phy_boot_access.sv
module phy_boot_access
  import phy_boot_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_write,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  output logic              fin,
  output logic              fin_err,
  output logic [DATA_W-1:0] fin_rdata,
  output logic              phy_req_valid,
  input  logic              phy_req_ready,
  output logic              phy_req_write,
  output logic [ADDR_W-1:0] phy_req_addr,
  output logic [DATA_W-1:0] phy_req_wdata,
  input  logic              phy_rsp_valid,
  input  logic [DATA_W-1:0] phy_rsp_rdata,
  input  logic              phy_rsp_err
);
  typedef enum logic [1:0] {E_IDLE, E_REQ, E_RSP} eng_e;

  eng_e              st;
  logic              lat_write;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              acc_expired;
  logic              got_rsp;
  logic              tmo_hit;

  phy_boot_timer #(.LIMIT(TIMEOUT_CYC)) u_acc_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (go),
    .en      (st != E_IDLE),
    .expired (acc_expired)
  );

  assign got_rsp = (st == E_RSP) && phy_rsp_valid;
  assign tmo_hit = acc_expired && !got_rsp &&
                   ((st == E_RSP) || ((st == E_REQ) && !phy_req_ready));

  assign phy_req_valid = (st == E_REQ);
  assign phy_req_write = lat_write;
  assign phy_req_addr  = lat_addr;
  assign phy_req_wdata = lat_wdata;

  assign fin       = got_rsp || tmo_hit;
  assign fin_err   = got_rsp ? phy_rsp_err : 1'b1;
  assign fin_rdata = phy_rsp_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      lat_write <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      case (st)
        E_IDLE: if (go) begin
          st        <= E_REQ;
          lat_write <= go_write;
          lat_addr  <= go_addr;
          lat_wdata <= go_write ? go_wdata : '0;
        end
        E_REQ: begin
          if (phy_req_ready)  st <= E_RSP;
          else if (tmo_hit)   st <= E_IDLE;
        end
        E_RSP: begin
          if (got_rsp || tmo_hit) st <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_valid && !phy_req_ready && !acc_expired |=>
      phy_req_valid && $stable(phy_req_addr) && $stable(phy_req_write) &&
      $stable(phy_req_wdata)); // R9

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_valid && phy_req_ready |=> !phy_req_valid); // R9

endmodule

// File: rtl/phy_boot_seq.sv
module phy_boot_seq
  import phy_boot_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned TIMEOUT_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              error,
  output logic              phy_req_valid,
  input  logic              phy_req_ready,
  output logic              phy_req_write,
  output logic [ADDR_W-1:0] phy_req_addr,
  output logic [DATA_W-1:0] phy_req_wdata,
  input  logic              phy_rsp_valid,
  input  logic [DATA_W-1:0] phy_rsp_rdata,
  input  logic              phy_rsp_err
);
  localparam int unsigned TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;
  localparam int          IW          = $clog2(STEP_COUNT);
  localparam logic [IW-1:0] LAST_IDX  = IW'(STEP_COUNT - 1);

  typedef enum logic [2:0] {
    S_STEP, S_WAIT_RD, S_WR_GO, S_WAIT_WR, S_DONE, S_FAIL
  } seq_e;

  seq_e              st;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] wr_buf;
  step_t             cur;

  logic              go, go_write;
  logic [DATA_W-1:0] go_wdata;
  logic              fin, fin_err;
  logic [DATA_W-1:0] fin_rdata;
  logic              poll_expired, poll_clr, poll_en;
  logic              finished, restart, advance;

  assign cur      = step_at(int'(idx));
  assign finished = (st == S_DONE) || (st == S_FAIL);
  assign restart  = finished && start;

  assign go       = (st == S_STEP) || (st == S_WR_GO);
  assign go_write = (st == S_WR_GO) || (cur.kind == K_WRITE);
  assign go_wdata = (st == S_WR_GO) ? wr_buf : cur.mask;

  // step advances: poll success, or successful write of a non-final step
  assign advance = ((st == S_WAIT_RD) && fin && !fin_err && (cur.kind == K_POLL) &&
                    fin_rdata[CAL_BIT]) ||
                   ((st == S_WAIT_WR) && fin && !fin_err && (idx != LAST_IDX));

  assign poll_clr = advance || restart;
  assign poll_en  = (cur.kind == K_POLL) && !finished;

  phy_boot_timer #(.LIMIT(TIMEOUT_CYC)) u_poll_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (poll_clr),
    .en      (poll_en),
    .expired (poll_expired)
  );

  phy_boot_access #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_access (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (go),
    .go_write      (go_write),
    .go_addr       (cur.addr),
    .go_wdata      (go_wdata),
    .fin           (fin),
    .fin_err       (fin_err),
    .fin_rdata     (fin_rdata),
    .phy_req_valid (phy_req_valid),
    .phy_req_ready (phy_req_ready),
    .phy_req_write (phy_req_write),
    .phy_req_addr  (phy_req_addr),
    .phy_req_wdata (phy_req_wdata),
    .phy_rsp_valid (phy_rsp_valid),
    .phy_rsp_rdata (phy_rsp_rdata),
    .phy_rsp_err   (phy_rsp_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_STEP;
      idx    <= '0;
      wr_buf <= '0;
    end else begin
      case (st)
        S_STEP: st <= (cur.kind == K_WRITE) ? S_WAIT_WR : S_WAIT_RD;
        S_WAIT_RD: if (fin) begin
          if (fin_err) begin
            st <= S_FAIL;
          end else if (cur.kind == K_POLL) begin
            if (fin_rdata[CAL_BIT]) begin
              idx <= idx + 1'b1;
              st  <= S_STEP;
            end else if (poll_expired) begin
              st <= S_FAIL;
            end else begin
              st <= S_STEP;
            end
          end else begin
            wr_buf <= fin_rdata | cur.mask;
            st     <= S_WR_GO;
          end
        end
        S_WR_GO: st <= S_WAIT_WR;
        S_WAIT_WR: if (fin) begin
          if (fin_err)               st <= S_FAIL;
          else if (idx == LAST_IDX)  st <= S_DONE;
          else begin
            idx <= idx + 1'b1;
            st  <= S_STEP;
          end
        end
        S_DONE, S_FAIL: if (start) begin
          idx <= '0;
          st  <= S_STEP;
        end
        default: st <= S_FAIL;
      endcase
    end
  end

  assign done  = (st == S_DONE);
  assign error = (st == S_FAIL);

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && !error); // R8

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error && !done); // R8

  AST_QUIET_WHEN_FINISHED: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !phy_req_valid); // R8

  AST_ABORT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rsp_valid && phy_rsp_err |=> !phy_req_valid && !done); // R6

  AST_MODE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_valid && phy_req_addr == 8'h11 |-> phy_req_write && phy_req_wdata == 8'h04); // R2

  AST_PAD_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_valid && phy_req_write && phy_req_addr == 8'h01 |->
      (phy_req_wdata & 8'h42) == 8'h42); // R3

endmodule

// File: tb/phy_boot_seq_test.sv
module phy_boot_seq_test;

  localparam int unsigned TMO = 200;   // CLK_MHZ 200 * TIMEOUT_US 1

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       done, error;
  logic       phy_req_valid, phy_req_write;
  logic       phy_req_ready = 1'b0;
  logic [7:0] phy_req_addr, phy_req_wdata;
  logic       phy_rsp_valid = 1'b0;
  logic [7:0] phy_rsp_rdata = 8'h00;
  logic       phy_rsp_err = 1'b0;

  always #2.5 clk = ~clk;

  phy_boot_seq #(.CLK_MHZ(200), .TIMEOUT_US(1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
    .phy_req_valid(phy_req_valid), .phy_req_ready(phy_req_ready),
    .phy_req_write(phy_req_write), .phy_req_addr(phy_req_addr),
    .phy_req_wdata(phy_req_wdata), .phy_rsp_valid(phy_rsp_valid),
    .phy_rsp_rdata(phy_rsp_rdata), .phy_rsp_err(phy_rsp_err)
  );

  int total = 0;
  int bad   = 0;

  // configuration written only by the main process
  logic [7:0] cfg_init [256];
  int         cfg_cal_need = 0;
  int         cfg_err_at   = -1;
  bit         cfg_hang     = 1'b0;
  int         reload_req   = 0;

  // PHY model state, owned by the model process
  logic [7:0] mem [256];
  int         reload_seen = 0;
  int         cal_cnt = 0;
  int         log_n = 0;
  bit         log_w [1024];
  logic [7:0] log_a [1024];
  logic [7:0] log_d [1024];
  bit         pending = 1'b0;
  int         lat = 0;
  logic [7:0] pend_rd = 8'h00;
  bit         pend_err = 1'b0;

  // handshake capture
  int         hs_cnt = 0;
  int         hs_seen = 0;
  bit         hs_w;
  logic [7:0] hs_a, hs_d;

  always @(posedge clk) begin
    if (phy_req_valid && phy_req_ready) begin
      hs_cnt <= hs_cnt + 1;
      hs_w   <= phy_req_write;
      hs_a   <= phy_req_addr;
      hs_d   <= phy_req_wdata;
    end
  end

  always @(negedge clk) begin
    phy_rsp_valid = 1'b0;
    phy_rsp_err   = 1'b0;
    if (reload_req != reload_seen) begin
      reload_seen = reload_req;
      for (int i = 0; i < 256; i++) mem[i] = cfg_init[i];
      cal_cnt = 0;
    end
    if (hs_cnt != hs_seen) begin
      hs_seen = hs_cnt;
      pend_err = (log_n == cfg_err_at);
      if (hs_w) begin
        mem[hs_a] = hs_d;
        pend_rd = 8'h00;
      end else if (hs_a == 8'h03) begin
        pend_rd = (mem[3] & 8'hEF) | ((cal_cnt >= cfg_cal_need) ? 8'h10 : 8'h00);
        cal_cnt++;
      end else begin
        pend_rd = mem[hs_a];
      end
      if (log_n < 1024) begin
        log_w[log_n] = hs_w;
        log_a[log_n] = hs_a;
        log_d[log_n] = hs_w ? hs_d : 8'h00;
      end
      log_n++;
      pending = 1'b1;
      lat = $urandom % 3;
      phy_req_ready = 1'b0;
    end
    if (pending) begin
      if (lat == 0) begin
        phy_rsp_valid = 1'b1;
        phy_rsp_rdata = pend_rd;
        phy_rsp_err   = pend_err;
        pending = 1'b0;
      end else begin
        lat--;
      end
    end else begin
      phy_req_ready = !cfg_hang && (($urandom % 4) != 0);
    end
  end

  // expected access list
  localparam logic [7:0] T_ADDR [11] = '{8'h01, 8'h02, 8'h06, 8'h08, 8'h20, 8'h07,
                                         8'h09, 8'h21, 8'h22, 8'h23, 8'h0F};
  localparam logic [7:0] T_MASK [11] = '{8'h42, 8'h02, 8'h03, 8'h02, 8'h01, 8'hFF,
                                         8'hFF, 8'hFF, 8'h01, 8'h01, 8'h07};
  int         exp_n;
  bit         exp_w [64];
  logic [7:0] exp_a [64];
  logic [7:0] exp_d [64];

  task automatic add_exp(input bit w, input logic [7:0] a, input logic [7:0] d);
    exp_w[exp_n] = w; exp_a[exp_n] = a; exp_d[exp_n] = d;
    exp_n++;
  endtask

  task automatic build_exp(input int cal);
    exp_n = 0;
    for (int s = 0; s < 11; s++) begin
      if (s == 2)
        for (int k = 0; k <= cal; k++) add_exp(1'b0, 8'h03, 8'h00);
      add_exp(1'b0, T_ADDR[s], 8'h00);
      add_exp(1'b1, T_ADDR[s], cfg_init[T_ADDR[s]] | T_MASK[s]);
    end
    add_exp(1'b1, 8'h11, 8'h04);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // compare the log from base against the first n expected entries
  task automatic chk_seq(input int base, input int n, input string tag);
    int mis = -1;
    for (int i = 0; i < n; i++)
      if (mis < 0 && (log_w[base+i] != exp_w[i] || log_a[base+i] != exp_a[i] ||
                      log_d[base+i] != exp_d[i])) mis = i;
    if (mis < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, int'({log_w[base+mis], log_a[base+mis], log_d[base+mis]}),
             int'({exp_w[mis], exp_a[mis], exp_d[mis]}));
  endtask

  task automatic new_image();
    for (int i = 0; i < 256; i++) cfg_init[i] = 8'($urandom);
    reload_req++;
    @(negedge clk);
  endtask

  task automatic pulse_start(input bit check_clear);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (check_clear) chk(!done && !error, "R1 flags cleared on start", {done, error}, 0);
  endtask

  task automatic wait_end(output int cyc);
    cyc = 0;
    while (!done && !error && cyc < 5000) begin
      @(negedge clk); cyc++;
    end
  endtask

  task automatic good_run(input int cal, input string tag);
    int base, cyc;
    cfg_cal_need = cal;
    new_image();
    build_exp(cal);
    base = log_n;
    pulse_start(1'b1);
    wait_end(cyc);
    chk(done && !error, {tag, " R8 done only"}, {done, error}, 2);
    chk(log_n - base == exp_n, {tag, " R2 access count"}, log_n - base, exp_n);
    chk_seq(base, exp_n, {tag, " R2/R3/R4 sequence"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base, cyc, k;
    void'($urandom(32'h5EED_1234));
    cfg_cal_need = 2;
    new_image();
    repeat (4) @(negedge clk);
    chk(!done && !error && !phy_req_valid, "R1 reset state",
        {done, error, phy_req_valid}, 0);

    // automatic run after reset
    build_exp(2);
    base = log_n;
    rst_n = 1'b1;
    wait_end(cyc);
    chk(done && !error, "R1 auto run done", {done, error}, 2);
    chk_seq(base, exp_n, "R1 auto run sequence");

    // sticky result and quiet port
    base = log_n;
    repeat (40) @(negedge clk);
    chk(done && !error && log_n == base, "R8 done held, no access", log_n - base, 0);

    // random images and calibration delays, plus immediate calibration
    good_run(0, "cal0");
    for (int r = 0; r < 6; r++) good_run($urandom % 7, "rand");

    // start while running is ignored
    cfg_cal_need = 3;
    new_image();
    build_exp(3);
    base = log_n;
    pulse_start(1'b1);
    repeat (6) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end(cyc);
    chk(done && log_n - base == exp_n, "R10 busy start ignored", log_n - base, exp_n);
    chk_seq(base, exp_n, "R10 sequence intact");

    // error response aborts at a chosen access
    for (int r = 0; r < 4; r++) begin
      cfg_cal_need = 1;
      new_image();
      build_exp(1);
      k = (r == 0) ? 0 : ((r == 1) ? exp_n - 1 : int'($urandom % exp_n));
      base = log_n;
      cfg_err_at = base + k;
      pulse_start(1'b1);
      wait_end(cyc);
      chk(error && !done, "R6 error on faulty response", {done, error}, 1);
      repeat (10) @(negedge clk);
      chk(log_n - base == k + 1, "R6 no access after fault", log_n - base, k + 1);
      chk_seq(base, k + 1, "R6 prefix order");
      cfg_err_at = -1;
    end

    // calibration never completes
    cfg_cal_need = 1000000;
    new_image();
    base = log_n;
    pulse_start(1'b1);
    wait_end(cyc);
    chk(error && !done, "R5 poll timeout error", {done, error}, 1);
    chk(cyc >= int'(TMO), "R5 poll lasted the window", cyc, TMO);
    chk(!log_w[log_n-1] && log_a[log_n-1] == 8'h03, "R5 last access is poll read",
        int'(log_a[log_n-1]), 3);

    // PHY never accepts a request
    cfg_hang = 1'b1;
    base = log_n;
    pulse_start(1'b1);
    wait_end(cyc);
    chk(error && !done, "R7 access timeout error", {done, error}, 1);
    chk(cyc >= int'(TMO), "R7 waited the window", cyc, TMO);
    chk(log_n == base, "R7 no accepted access", log_n - base, 0);
    repeat (2) @(negedge clk);
    cfg_hang = 1'b0;

    // recovery after error
    good_run(4, "recover");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule